// File: doc/BRIEF.md
# Prioritized Microcontroller Interrupt Controller

This block gathers the interrupt events of a small processor core into one 8-bit control-and-flag register. It watches three sources: a single external pin, whose active edge is chosen by a separate edge-select input; an overflow pulse from an 8-bit timer; and any level change on an 8-bit input port. Each event sets a sticky flag. The flag is masked by its own enable bit and then by one global enable. The result drives a single request line to the CPU.

The CPU accepts the request by pulsing an acknowledge. In that cycle the block tells the core to push its return address onto the hardware stack. It also presents the fixed entry vector 0x0004. On the next edge it drops the global enable, so interrupts cannot nest. Software finds the source by reading the flags, and clears a flag by writing a 0 to it. A return-from-interrupt pulse turns the global enable back on. A flag that is still set then raises the request again.

Top module: `irq_ctl`

## Requirements
- R1: After reset the control register reads 0x00 and the request is low. Pin or port levels present at reset do not set any flag.
- R2: The control register is read and written as one byte. Bit 7 is the global enable, bit 6 a spare storage bit, bit 5 the timer enable, bit 4 the pin enable and bit 3 the port enable. Bit 2 is the timer flag, bit 1 the pin flag and bit 0 the port flag.
- R3: A one-cycle timer overflow pulse sampled high sets bit 2 at that clock edge.
- R4: The external pin passes through a two-flop synchronizer. With edge-select 1 only a rising edge sets bit 1, and with 0 only a falling edge does. The flag is visible two edges after the edge that first samples the pin.
- R5: A change on any one of the port pins, after two-flop synchronization, sets bit 0.
- R6: A flag sets whatever its enable is. The request is high exactly when bit 7 is 1 and at least one flag has its enable set.
- R7: When a register write that clears a flag coincides with a set event for that flag, the flag ends up set.
- R8: When acknowledge is high while the request is high, push is high in that cycle and the vector reads 0x0004. Bit 7 is then 0 after the edge. An acknowledge without a request changes nothing and gives no push.
- R9: A return pulse sets bit 7. A flag still pending with its enable set raises the request again.
- R10: Hardware never clears a flag. Only a register write does, so taking an interrupt leaves the flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Current register contents |
| edge_rise | input | 1 | Pin edge select: 1 rising, 0 falling |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| port_pins | input | PORT_W | Input port watched for changes (asynchronous) |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| irq_ack | input | 1 | CPU accepts the interrupt |
| irq_ret | input | 1 | CPU returns from the service routine |
| irq_req | output | 1 | Interrupt request to the CPU |
| push_ret | output | 1 | Push the return address this cycle |
| vec_addr | output | PC_W | Entry vector for the program counter |

## Verification
The bench uses the defaults: an 8-pin port, a 13-bit program counter and vector 0x0004. At these values single-pin changes at both ends of the port can be exercised, and the vector can be compared as a full 13-bit word. Both edge-select settings are run against rising and falling pin edges. The collisions are checked one by one: a write against a set event, an acknowledge with no request, and a reset with the pins held high.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int PORT_W = 8,
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VECTOR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              edge_rise,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              tmr_ovf,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic              push_ret,
  output logic [PC_W-1:0]   vec_addr
);
  logic ext_s1, ext_s2, ext_q;
  logic [PORT_W-1:0] port_s1, port_s2, port_q;
  logic [1:0] warm;
  logic live;

  logic gen, spare, en_t, en_x, en_p, f_t, f_x, f_p;
  logic ext_hit, port_hit, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1  <= 1'b0;
      ext_s2  <= 1'b0;
      ext_q   <= 1'b0;
      port_s1 <= '0;
      port_s2 <= '0;
      port_q  <= '0;
      warm    <= 2'd0;
    end else begin
      ext_s1  <= ext_pin;
      ext_s2  <= ext_s1;
      ext_q   <= ext_s2;
      port_s1 <= port_pins;
      port_s2 <= port_s1;
      port_q  <= port_s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign live     = (warm == 2'd3);
  assign ext_hit  = live & (edge_rise ? (ext_s2 & ~ext_q) : (~ext_s2 & ext_q));
  assign port_hit = live & (|(port_s2 ^ port_q));
  assign take     = irq_ack & irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen   <= 1'b0;
      spare <= 1'b0;
      en_t  <= 1'b0;
      en_x  <= 1'b0;
      en_p  <= 1'b0;
      f_t   <= 1'b0;
      f_x   <= 1'b0;
      f_p   <= 1'b0;
    end else begin
      if (take)        gen <= 1'b0;
      else if (ctl_we) gen <= ctl_wdata[7];
      else if (irq_ret) gen <= 1'b1;
      if (ctl_we) begin
        spare <= ctl_wdata[6];
        en_t  <= ctl_wdata[5];
        en_x  <= ctl_wdata[4];
        en_p  <= ctl_wdata[3];
      end
      f_t <= (ctl_we ? ctl_wdata[2] : f_t) | tmr_ovf;
      f_x <= (ctl_we ? ctl_wdata[1] : f_x) | ext_hit;
      f_p <= (ctl_we ? ctl_wdata[0] : f_p) | port_hit;
    end
  end

  assign ctl_rdata = {gen, spare, en_t, en_x, en_p, f_t, f_x, f_p};
  assign irq_req   = gen & ((f_t & en_t) | (f_x & en_x) | (f_p & en_p));
  assign push_ret  = take;
  assign vec_addr  = VECTOR;
endmodule

module irq_ctl_chk #(
  parameter int PORT_W = 8,
  parameter int PC_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [7:0]        ctl_rdata,
  input logic              tmr_ovf,
  input logic              irq_ack,
  input logic              irq_ret,
  input logic              irq_req,
  input logic              push_ret,
  input logic [PC_W-1:0]   vec_addr
);
  p_req_needs_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ctl_rdata[7]);
  p_ack_drops_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !ctl_rdata[7]);
  p_push_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret |-> (irq_req && vec_addr == PC_W'(4)));
  p_tmr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctl_rdata[2]);
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2] && !ctl_we) |=> ctl_rdata[2]);
  p_ret_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && !ctl_we) |=> ctl_rdata[7]);
endmodule

bind irq_ctl irq_ctl_chk #(.PORT_W(PORT_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/irq_ctl_tb.sv
`timescale 1ns/1ps
module irq_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic edge_rise = 1'b1;
  logic ext_pin = 1'b0;
  logic [7:0] port_pins = 8'h00;
  logic tmr_ovf = 1'b0;
  logic irq_ack = 1'b0;
  logic irq_ret = 1'b0;
  logic irq_req, push_ret;
  logic [12:0] vec_addr;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_ctl u_dut (.*);

  // {we, wdata, ext, port, tmr, rise, exp_ctl, exp_irq}
  localparam int NV = 15;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h38, 1'b0, 8'h00, 1'b0, 1'b1, 8'h38, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b0},
    {1'b1, 8'hBC, 1'b0, 8'h00, 1'b0, 1'b1, 8'hBC, 1'b1},
    {1'b1, 8'hB8, 1'b0, 8'h00, 1'b0, 1'b1, 8'hB8, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1, 8'hBA, 1'b1},
    {1'b1, 8'hB8, 1'b1, 8'h00, 1'b0, 1'b1, 8'hB8, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'hB8, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'hB8, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'hBA, 1'b1},
    {1'b1, 8'hB8, 1'b0, 8'h00, 1'b0, 1'b0, 8'hB8, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h10, 1'b0, 1'b0, 8'hB9, 1'b1},
    {1'b1, 8'hB1, 1'b0, 8'h10, 1'b0, 1'b0, 8'hB1, 1'b0},
    {1'b1, 8'h09, 1'b0, 8'h10, 1'b0, 1'b0, 8'h09, 1'b0},
    {1'b1, 8'h40, 1'b0, 8'h10, 1'b0, 1'b0, 8'h40, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h11, 1'b0, 1'b0, 8'h41, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 reset ctl", ctl_rdata, 8'h00);
    check("R1 reset irq", irq_req, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      @(negedge clk);
      ctl_we = v[28]; ctl_wdata = v[27:20]; ext_pin = v[19];
      port_pins = v[18:11]; tmr_ovf = v[10]; edge_rise = v[9];
      @(negedge clk);
      ctl_we = 1'b0; tmr_ovf = 1'b0;
      repeat (3) @(negedge clk);
      check($sformatf("R2 R3 R4 R5 R6 vec %0d ctl", i), ctl_rdata, v[8:1]);
      check($sformatf("R6 vec %0d irq", i), irq_req, v[0]);
    end

    // R8 R10: acknowledge with a port flag pending and enabled
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h89;
    @(negedge clk); ctl_we = 1'b0;
    check("R6 pending irq", irq_req, 1'b1);
    irq_ack = 1'b1;
    #1;
    check("R8 push on ack", push_ret, 1'b1);
    check("R8 vector", vec_addr, 13'h0004);
    @(negedge clk); irq_ack = 1'b0;
    check("R8 R10 ctl after ack", ctl_rdata, 8'h09);
    check("R8 irq after ack", irq_req, 1'b0);

    // R9: return re-enables and the kept flag requests again
    irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    check("R9 ctl after ret", ctl_rdata, 8'h89);
    check("R9 repeat irq", irq_req, 1'b1);

    // R7: clearing write collides with a timer set event
    ctl_we = 1'b1; ctl_wdata = 8'h80; tmr_ovf = 1'b1;
    @(negedge clk); ctl_we = 1'b0; tmr_ovf = 1'b0;
    check("R7 set wins", ctl_rdata, 8'h84);
    check("R6 masked irq", irq_req, 1'b0);

    // R8: acknowledge without a request is ignored
    irq_ack = 1'b1;
    #1;
    check("R8 no push", push_ret, 1'b0);
    @(negedge clk); irq_ack = 1'b0;
    check("R8 ack ignored", ctl_rdata, 8'h84);

    // R4: falling select, rising edge at the upper port bit too
    ctl_we = 1'b1; ctl_wdata = 8'h00;
    @(negedge clk); ctl_we = 1'b0;
    port_pins = 8'h91;
    repeat (4) @(negedge clk);
    check("R5 upper pin change", ctl_rdata, 8'h01);

    // R1: reset with inputs held high sets no flag
    rst_n = 1'b0; ext_pin = 1'b1; port_pins = 8'hFF; edge_rise = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 no spurious flag", ctl_rdata, 8'h00);
    check("R1 irq low", irq_req, 1'b0);

    finish_run();
  end
endmodule